// File: doc/BRIEF.md
# Edge Timestamp Capture Timer

A free-running up-counter, paced by a programmable prescaler, is sampled whenever the selected edge of an asynchronous input arrives. Each sample (a timestamp) is written into a small local buffer at the next free slot. Software programs how many timestamps make up a burst and arms the capture with a start command. When the final timestamp of the burst is stored, a completion interrupt is raised and further edges are ignored until the next start. A typical use is decoding a pulse-width-coded serial line: one burst collects a preamble edge plus a fixed number of data edges, and the spacing between consecutive timestamps gives each pulse length.

The counter runs from zero up to a programmable reload value and then wraps. Each wrap raises a timeout interrupt, so a lower reload value gives a shorter frame timeout. The block also offers the difference between the two newest timestamps of the current burst. This difference is corrected for counter wrap, so a pulse length can be read without any arithmetic in software. A new prescaler value is staged by a register write. It is applied only by an update command, which also clears the counter.

The capture sequencer is a four-state machine:
- `ST_IDLE`: not armed. This is the state after reset.
- `ST_ARMED`: waiting for an edge.
- `ST_STORE`: writing the latched timestamp into the buffer.
- `ST_DONE`: the burst is complete.

Its transitions are:
- IDLE→ARMED on start.
- ARMED→STORE on a selected edge.
- STORE→ARMED when the burst is not yet full.
- STORE→DONE on the last capture.
- Any state→ARMED on start, which restarts the burst.

Top module: `capture_burst_timer`

## Requirements
- R1: After reset, `irq_done`, `irq_timeout`, `ovc_flag`, `busy` and `delta_valid` are 0. The counter is stopped, the prescaler divide value is 0, the reload value is 0xFFFF, the capture mode is rising edge (code 00) and the burst length is DEPTH.
- R2: Register 0 stages a prescaler value P, and the counter then advances once every P+1 clocks. A staged value has no effect until a command write with bit 0 set (update). The update loads the staged value, clears the prescale phase and clears the counter. The counter advances only while bit 2 of register 2 is 1.
- R3: Register 1 holds the reload value. On the tick where the counter equals or exceeds it, the counter returns to 0 and `irq_timeout` becomes 1 and stays 1 until cleared. An update command clears the counter without setting the flag.
- R4: Register 2 bits [1:0] select the capture edge: 00 rising, 01 falling, 11 both, 10 none. The input passes through a two-stage synchronizer before edge detection.
- R5: Each accepted edge latches the counter value. One clock later this value is written to buffer slot 0, 1, 2, … in order, and `rd_data` shows the slot addressed by `rd_addr`.
- R6: When the number of stored timestamps reaches the burst length, `irq_done` becomes 1 and `busy` becomes 0. Later edges change neither the buffer nor `delta` until the next start.
- R7: A burst length written as 0 acts as 1, and a length above DEPTH acts as DEPTH.
- R8: An edge that arrives in the cycle while the previous timestamp is being stored is dropped, and it sets `ovc_flag`.
- R9: From the second timestamp of a burst on, `delta_valid` is 1. `delta` equals newest minus previous timestamp, with reload+1 added when that subtraction is negative.
- R10: A command write with bit 2 set clears `irq_done`, `irq_timeout` and `ovc_flag`.
- R11: A command write with bit 1 set (start) arms the sequencer, restarts storage at slot 0 and clears `delta_valid`, whatever the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 prescaler, 1 reload, 2 control, 3 burst length, 4 command |
| wr_data | input | CNT_W (16) | Register write data |
| cap_in | input | 1 | Asynchronous capture input |
| rd_addr | input | IDX_W (6) | Buffer read slot |
| rd_data | output | CNT_W (16) | Timestamp stored in the addressed slot |
| irq_done | output | 1 | Burst complete flag |
| irq_timeout | output | 1 | Counter wrap (timeout) flag |
| ovc_flag | output | 1 | Dropped-edge (overcapture) flag |
| busy | output | 1 | Sequencer armed or storing |
| delta | output | CNT_W (16) | Wrap-corrected difference of the two newest timestamps |
| delta_valid | output | 1 | At least two timestamps stored in this burst |

## Verification
The assertions assume that the reload value is not lowered while a burst is running. They also assume that the prescaler register changes only through the update path, so every timestamp and every difference stays within the current reload range. The stimulus keeps to these assumptions: reload and prescaler are written only in the setup step before each start command. Within a burst, random edge spacings stay below the reload value, so each wrap-corrected difference has only one possible value. Back-to-back edges appear only in the directed overcapture case.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_STORE = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_t;

    // register select codes
    localparam logic [2:0] A_PSC    = 3'd0;
    localparam logic [2:0] A_RELOAD = 3'd1;
    localparam logic [2:0] A_CTRL   = 3'd2;
    localparam logic [2:0] A_LEN    = 3'd3;
    localparam logic [2:0] A_CMD    = 3'd4;

    // command bits
    localparam int CMD_UPDATE = 0;
    localparam int CMD_START  = 1;
    localparam int CMD_CLEAR  = 2;

    // control bits
    localparam int CTRL_RUN = 2;

    // edge mode codes
    localparam logic [1:0] POL_RISE = 2'b00;
    localparam logic [1:0] POL_FALL = 2'b01;
    localparam logic [1:0] POL_NONE = 2'b10;
    localparam logic [1:0] POL_BOTH = 2'b11;

endpackage

// File: rtl/cbt_timebase.sv
module cbt_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             update,
    input  logic [CNT_W-1:0] psc_staged,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    logic [CNT_W-1:0] psc_live;
    logic [CNT_W-1:0] phase;
    logic             tick;

    assign tick = run && !update && (phase >= psc_live);
    assign wrap = tick && (count >= reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_live <= '0;
            phase    <= '0;
            count    <= '0;
        end else if (update) begin
            psc_live <= psc_staged;
            phase    <= '0;
            count    <= '0;
        end else if (run) begin
            if (phase >= psc_live) begin
                phase <= '0;
                if (count >= reload) begin
                    count <= '0;
                end else begin
                    count <= count + 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= psc_live);

    // R2
    update_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (count == '0) && (phase == '0));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !update) |=> $stable(count));

endmodule

// File: rtl/cbt_edge_detect.sv
module cbt_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] mode,
    output logic       hit
);
    import cbt_pkg::*;

    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] pipe;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], din};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];

    always_comb begin
        unique case (mode)
            POL_RISE: hit = rise;
            POL_FALL: hit = fall;
            POL_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end

    // R4
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == POL_NONE) |-> !hit);

endmodule

// File: rtl/cbt_delta.sv
module cbt_delta #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] newer,
    input  logic [CNT_W-1:0] older,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] diff
);

    logic [CNT_W-1:0] raw;

    // modulo 2^CNT_W arithmetic; adding reload+1 folds a negative raw
    // difference back into 0..reload
    assign raw = newer - older;

    always_comb begin
        if (newer >= older) begin
            diff = raw;
        end else begin
            diff = raw + reload + 1'b1;
        end
    end

endmodule

// File: rtl/cbt_capture_fsm.sv
module cbt_capture_fsm #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 64,
    parameter int LEN_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             edge_hit,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] reload,
    input  logic [LEN_W-1:0] burst_len,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             busy,
    output logic             done_set,
    output logic             ovc_set,
    output logic [CNT_W-1:0] delta,
    output logic             delta_valid
);
    import cbt_pkg::*;

    cap_state_t       state, state_nx;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] newest_q;
    logic [LEN_W-1:0] stored_q;
    logic             have_one_q;
    logic             last_slot;
    logic [CNT_W-1:0] diff_w;
    logic [CNT_W-1:0] mem [DEPTH];

    assign last_slot = (LEN_W'(stored_q + 1'b1) == burst_len);

    cbt_delta #(.CNT_W(CNT_W)) u_delta (
        .newer  (latch_q),
        .older  (newest_q),
        .reload (reload),
        .diff   (diff_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (start)         state_nx = ST_ARMED;
                else if (edge_hit) state_nx = ST_STORE;
            end
            ST_STORE: begin
                if (start)          state_nx = ST_ARMED;
                else if (last_slot) state_nx = ST_DONE;
                else                state_nx = ST_ARMED;
            end
            ST_DONE:  if (start) state_nx = ST_ARMED;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q     <= '0;
            newest_q    <= '0;
            stored_q    <= '0;
            have_one_q  <= 1'b0;
            delta       <= '0;
            delta_valid <= 1'b0;
        end else if (start) begin
            stored_q    <= '0;
            have_one_q  <= 1'b0;
            delta_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    if (edge_hit) latch_q <= count;
                end
                ST_STORE: begin
                    stored_q   <= stored_q + 1'b1;
                    newest_q   <= latch_q;
                    have_one_q <= 1'b1;
                    if (have_one_q) begin
                        delta       <= diff_w;
                        delta_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_STORE && !start) begin
            mem[stored_q[IDX_W-1:0]] <= latch_q;
        end
    end

    assign rd_data  = mem[rd_addr];
    assign busy     = (state == ST_ARMED) || (state == ST_STORE);
    assign done_set = (state == ST_STORE) && !start && last_slot;
    assign ovc_set  = (state == ST_STORE) && !start && edge_hit;

    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |-> (stored_q < burst_len));

    // R6
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !start) |=> $stable(stored_q) && $stable(delta));

    // R9
    delta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && !start && have_one_q &&
         latch_q <= reload && newest_q <= reload)
        |=> delta <= $past(reload));

    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !delta_valid && (stored_q == '0) && (state == ST_ARMED));

endmodule

// File: rtl/capture_burst_timer.sv
module capture_burst_timer #(
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 64,
    parameter int STAGES = 2,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_in,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_done,
    output logic             irq_timeout,
    output logic             ovc_flag,
    output logic             busy,
    output logic [CNT_W-1:0] delta,
    output logic             delta_valid
);
    import cbt_pkg::*;

    logic [CNT_W-1:0] psc_staged;
    logic [CNT_W-1:0] reload;
    logic [1:0]       mode;
    logic             run;
    logic [LEN_W-1:0] burst_len;
    logic             cmd_wr;
    logic             do_update;
    logic             do_start;
    logic             do_clear;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             edge_hit;
    logic             done_set;
    logic             ovc_set;

    assign cmd_wr    = wr_en && (wr_addr == A_CMD);
    assign do_update = cmd_wr && wr_data[CMD_UPDATE];
    assign do_start  = cmd_wr && wr_data[CMD_START];
    assign do_clear  = cmd_wr && wr_data[CMD_CLEAR];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_staged <= '0;
            reload     <= '1;
            mode       <= POL_RISE;
            run        <= 1'b0;
            burst_len  <= LEN_W'(DEPTH);
        end else if (wr_en) begin
            unique case (wr_addr)
                A_PSC:    psc_staged <= wr_data;
                A_RELOAD: reload     <= wr_data;
                A_CTRL: begin
                    mode <= wr_data[1:0];
                    run  <= wr_data[CTRL_RUN];
                end
                A_LEN: begin
                    if (wr_data == '0) begin
                        burst_len <= LEN_W'(1);
                    end else if (wr_data > CNT_W'(DEPTH)) begin
                        burst_len <= LEN_W'(DEPTH);
                    end else begin
                        burst_len <= wr_data[LEN_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // sticky flags: a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_done    <= 1'b0;
            irq_timeout <= 1'b0;
            ovc_flag    <= 1'b0;
        end else begin
            irq_done    <= done_set || (irq_done    && !do_clear);
            irq_timeout <= wrap     || (irq_timeout && !do_clear);
            ovc_flag    <= ovc_set  || (ovc_flag    && !do_clear);
        end
    end

    cbt_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .update     (do_update),
        .psc_staged (psc_staged),
        .reload     (reload),
        .count      (count),
        .wrap       (wrap)
    );

    cbt_edge_detect #(.STAGES(STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .mode  (mode),
        .hit   (edge_hit)
    );

    cbt_capture_fsm #(
        .CNT_W (CNT_W),
        .DEPTH (DEPTH),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (do_start),
        .edge_hit    (edge_hit),
        .count       (count),
        .reload      (reload),
        .burst_len   (burst_len),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .done_set    (done_set),
        .ovc_set     (ovc_set),
        .delta       (delta),
        .delta_valid (delta_valid)
    );

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_done) |-> !busy);

    // R8
    ovc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovc_flag) |-> $past(busy));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clear && !wrap && !done_set && !ovc_set)
        |=> !irq_done && !irq_timeout && !ovc_flag);

    // R7
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_len != '0) && (burst_len <= LEN_W'(DEPTH)));

endmodule

// File: tb/sim_capture_burst_timer.sv
module sim_capture_burst_timer;

    localparam int CNT_W = 16;
    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             cap_in = 1'b0;
    logic [IDX_W-1:0] rd_addr = '0;
    logic [CNT_W-1:0] rd_data;
    logic             irq_done, irq_timeout, ovc_flag, busy, delta_valid;
    logic [CNT_W-1:0] delta;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    capture_burst_timer #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_in(cap_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_done(irq_done), .irq_timeout(irq_timeout),
        .ovc_flag(ovc_flag), .busy(busy), .delta(delta),
        .delta_valid(delta_valid)
    );

    function automatic int wrapdiff(int newer, int older, int rl);
        int d;
        d = newer - older;
        if (d < 0) d = d + rl + 1;
        return d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // prescaler, reload, edge mode, length, then update+start+clear
    task automatic setup(input int p, input int rl, input int md, input int len);
        wr(3'd0, p);
        wr(3'd1, rl);
        wr(3'd2, 4 | md);
        wr(3'd3, len);
        wr(3'd4, 7);
        idle(4);
    endtask

    task automatic toggle_wait(input int n);
        cap_in = ~cap_in;
        idle(n);
    endtask

    function automatic int read_slot(input int i);
        return 0;
    endfunction

    int slot_v [8];

    task automatic read_slots(input int n);
        for (int i = 0; i < n; i++) begin
            rd_addr = IDX_W'(i);
            #1;
            slot_v[i] = int'(rd_data);
        end
    endtask

    // polarity burst: rise@0, fall@4, rise@10, fall@20
    task automatic pattern_burst(input int md);
        setup(0, 65535, md, 2);
        toggle_wait(4);
        toggle_wait(6);
        toggle_wait(10);
        toggle_wait(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ks [8];
        int p, rl, len, v0;
        void'($urandom(32'h5eed));
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq_done", int'(irq_done), 0);
        check("R1 irq_timeout", int'(irq_timeout), 0);
        check("R1 ovc_flag", int'(ovc_flag), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 delta_valid", int'(delta_valid), 0);
        idle(20);
        check("R1 counter stopped, no timeout", int'(irq_timeout), 0);

        // R3 timeout on wrap, reload 30
        setup(0, 30, 3, 4);
        idle(14);
        check("R3 no early timeout", int'(irq_timeout), 0);
        idle(20);
        check("R3 timeout after wrap", int'(irq_timeout), 1);
        wr(3'd2, 3);
        wr(3'd4, 4);
        check("R10 clear timeout", int'(irq_timeout), 0);
        idle(70);
        check("R2 stopped counter gives no timeout", int'(irq_timeout), 0);

        // R4 edge modes
        pattern_burst(0);
        check("R4 rising delta", int'(delta), 10);
        check("R4 rising done", int'(irq_done), 1);
        pattern_burst(1);
        check("R4 falling delta", int'(delta), 16);
        pattern_burst(3);
        check("R4 both-edge delta", int'(delta), 4);
        read_slots(1);
        v0 = slot_v[0];
        // R6: after done, more edges are ignored
        toggle_wait(5);
        toggle_wait(5);
        read_slots(1);
        check("R6 slot 0 unchanged after done", slot_v[0], v0);
        check("R6 delta unchanged after done", int'(delta), 4);
        check("R6 busy low after done", int'(busy), 0);
        pattern_burst(2);
        check("R4 mode 10 captures nothing", int'(irq_done), 0);
        check("R4 mode 10 stays armed", int'(busy), 1);

        // R2 staged prescaler without update has no effect
        setup(0, 65535, 3, 3);
        wr(3'd0, 3);
        idle(2);
        toggle_wait(8);
        toggle_wait(8);
        toggle_wait(8);
        check("R2 staged prescaler ignored", int'(delta), 8);
        setup(3, 65535, 3, 3);
        toggle_wait(8);
        toggle_wait(8);
        toggle_wait(8);
        check("R2 prescaler 3 after update", int'(delta), 2);

        // R8 overcapture: three back-to-back edges
        setup(0, 65535, 3, 2);
        toggle_wait(1);
        toggle_wait(1);
        toggle_wait(8);
        check("R8 ovc_flag set", int'(ovc_flag), 1);
        check("R8 dropped edge skipped", int'(delta), 2);
        check("R8 done", int'(irq_done), 1);
        wr(3'd4, 4);
        check("R10 clear done and ovc", int'(irq_done) + int'(ovc_flag), 0);

        // R7 length clamp
        setup(0, 65535, 3, 0);
        toggle_wait(6);
        check("R7 length 0 acts as 1", int'(irq_done), 1);
        check("R7 one capture no delta", int'(delta_valid), 0);
        setup(0, 65535, 3, 200);
        for (int i = 0; i < 63; i++) toggle_wait(3);
        idle(3);
        check("R7 not done after 63", int'(irq_done), 0);
        toggle_wait(6);
        check("R7 done at DEPTH", int'(irq_done), 1);

        // R11 restart mid-burst
        setup(0, 65535, 3, 4);
        toggle_wait(5);
        toggle_wait(5);
        wr(3'd4, 2);
        check("R11 delta_valid cleared", int'(delta_valid), 0);
        idle(3);
        toggle_wait(7);
        toggle_wait(6);
        read_slots(2);
        check("R11 restart from slot 0", wrapdiff(slot_v[1], slot_v[0], 65535), 7);
        check("R11 still busy", int'(busy), 1);

        // R5 R9 random bursts with wrap
        for (int it = 0; it < 10; it++) begin
            p   = $urandom_range(0, 2);
            rl  = $urandom_range(40, 300);
            len = $urandom_range(3, 8);
            for (int i = 0; i < 8; i++) ks[i] = $urandom_range(2, 30);
            setup(p, rl, 3, len);
            for (int i = 0; i < len; i++) begin
                if (i == len - 1) toggle_wait(8 * (p + 1));
                else toggle_wait(ks[i] * (p + 1));
            end
            idle(4);
            check("R6 random burst done", int'(irq_done), 1);
            read_slots(len);
            for (int i = 1; i < len; i++) begin
                check("R5 slot spacing", wrapdiff(slot_v[i], slot_v[i-1], rl), ks[i-1]);
                check("R5 slot within reload", int'(slot_v[i] <= rl), 1);
            end
            check("R9 delta_valid", int'(delta_valid), 1);
            check("R9 wrap-corrected delta", int'(delta), ks[len-2]);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule